// File: doc/BRIEF.md
# Serial Ones Counter with Shift-Out Flag

This block counts how many bits of a data word are set to one. It does this one bit at a time under a small control state machine, and it has no adder tree. A one-cycle `start` pulse while the block is idle captures `din` into a work register and clears the tally register. The controller then repeats a two-state step. First, the most significant bit of the work register is moved into a one-bit flag flip-flop and the word is shifted left by one. Then the tally register is incremented if that flag is set.

The sequence ends as soon as the work register holds only zeros, so a word whose low bits are clear finishes early. The controller then spends one cycle in a finish state, where `done` is high and `count` already carries the final tally. After that it returns to idle. The tally is held at the output until the next accepted start.

The controller has four states:
- IDLE: waits. The go transition on `start` loads the word.
- SCAN: takes the step transition to TALLY while the word is non-zero, or the empty transition to FINISH once it is zero.
- TALLY: takes the back transition to SCAN, bumping the tally when the flag is set.
- FINISH: takes the release transition to IDLE.

The next state is picked by a two-way multiplexer. Each state supplies its select condition and two candidate targets.

Top module: `ocnt_top`

## Requirements
- R1: A synchronous active-high `rst` forces the controller to IDLE and clears the work register, the flag and the tally. This holds even in the middle of a run. On the cycle after reset, `busy`=0, `done`=0 and `count`=0.
- R2: A `start` sampled high while `busy`=0 loads `din` and clears the tally. On the next cycle `busy`=1 and `count`=0.
- R3: When `done` is high, `count` equals the number of one bits in the word that was loaded.
- R4: `done` is high for exactly one cycle per run. On the following cycle `done`=0 and `busy`=0.
- R5: Counting from the edge that samples `start`, `done` is high after exactly 2 + 2·S edges. S is 0 for an all-zero word. Otherwise S is WIDTH minus the bit index (0 = LSB) of the lowest set bit, so the run stops early once the remaining bits are zero.
- R6: A `start` that arrives while `busy`=1 is ignored. Neither the result nor the latency of the current run changes.
- R7: While `busy`=0 and `start`=0, `count` keeps its value.
- R8: WIDTH is a parameter, 8 by default. `count` is clog2(WIDTH+1) bits wide and never exceeds WIDTH, so an all-ones word reports WIDTH.
- R9: During a run, `count` changes by at most +1 per cycle and never decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a count; only acted on when idle |
| din | input | WIDTH | Word whose set bits are counted |
| busy | output | 1 | High in every state except IDLE |
| done | output | 1 | One-cycle pulse in the FINISH state |
| count | output | clog2(WIDTH+1) | Tally register; final value while `done` is high |

## Verification
A corrupted work register or flag shows up two ways. `count` disagrees with the popcount at the `done` pulse, and the pulse lands on a different edge than 2 + 2·S. Both are visible within one run, at most 2·WIDTH + 2 cycles after start. A wrong controller state shows up as a missing, doubled or misplaced `done` pulse, as `busy` staying high or dropping early, or as `count` moving while idle. These appear on the cycle after the bad transition. A start injected mid-run exposes a controller that re-loads while busy, because the result then belongs to the second word.

// File: rtl/ocnt_pkg.sv
package ocnt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_TALLY  = 2'd2,
        ST_FINISH = 2'd3
    } ocnt_state_e;

endpackage

// File: rtl/ocnt_dp.sv
module ocnt_dp #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic             shift,
    input  logic             tally,
    input  logic [WIDTH-1:0] din,
    output logic             a_zero,
    output logic [CNT_W-1:0] count
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] work_q;
    logic             flag_q;
    logic [CNT_W-1:0] tally_q;

    // work register: loaded from din, then drained from the top
    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
        end else if (ld) begin
            work_q <= din;
        end else if (shift) begin
            work_q <= {work_q[MSB-1:0], 1'b0};
        end
    end

    // single-bit flag catches the bit leaving the top
    always_ff @(posedge clk) begin
        if (rst || ld) begin
            flag_q <= 1'b0;
        end else if (shift) begin
            flag_q <= work_q[MSB];
        end
    end

    // tally register
    always_ff @(posedge clk) begin
        if (rst || ld) begin
            tally_q <= '0;
        end else if (tally && flag_q) begin
            tally_q <= tally_q + 1'b1;
        end
    end

    assign a_zero = (work_q == '0);
    assign count  = tally_q;

endmodule

// File: rtl/ocnt_ctrl.sv
module ocnt_ctrl
    import ocnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic a_zero,
    output logic ld,
    output logic shift,
    output logic tally,
    output logic busy,
    output logic done
);

    ocnt_state_e state_q, nxt;
    ocnt_state_e tgt_lo, tgt_hi;
    logic        sel;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= nxt;
        end
    end

    // next-state multiplexer: each state supplies a select and two targets
    always_comb begin
        sel    = 1'b0;
        tgt_lo = ST_IDLE;
        tgt_hi = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                sel    = start;
                tgt_lo = ST_IDLE;
                tgt_hi = ST_SCAN;
            end
            ST_SCAN: begin
                sel    = a_zero;
                tgt_lo = ST_TALLY;
                tgt_hi = ST_FINISH;
            end
            ST_TALLY: begin
                sel    = 1'b0;
                tgt_lo = ST_SCAN;
                tgt_hi = ST_SCAN;
            end
            ST_FINISH: begin
                sel    = 1'b0;
                tgt_lo = ST_IDLE;
                tgt_hi = ST_IDLE;
            end
            default: begin
                sel    = 1'b0;
                tgt_lo = ST_IDLE;
                tgt_hi = ST_IDLE;
            end
        endcase
        nxt = sel ? tgt_hi : tgt_lo;
    end

    // control outputs
    always_comb begin
        ld    = 1'b0;
        shift = 1'b0;
        tally = 1'b0;
        busy  = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                ld   = start;
            end
            ST_SCAN:   shift = ~a_zero;
            ST_TALLY:  tally = 1'b1;
            ST_FINISH: done  = 1'b1;
            default:   busy  = 1'b0;
        endcase
    end

endmodule

// File: rtl/ocnt_top.sv
module ocnt_top #(
    parameter  int WIDTH = 8,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] din,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] count
);

    logic ld, shift, tally, a_zero;

    ocnt_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .a_zero (a_zero),
        .ld     (ld),
        .shift  (shift),
        .tally  (tally),
        .busy   (busy),
        .done   (done)
    );

    ocnt_dp #(
        .WIDTH (WIDTH),
        .CNT_W (CNT_W)
    ) u_dp (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld),
        .shift  (shift),
        .tally  (tally),
        .din    (din),
        .a_zero (a_zero),
        .count  (count)
    );

endmodule

// File: rtl/ocnt_chk.sv
module ocnt_chk #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] count
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && !done && count == '0));

    a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && count == '0));

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r4_done_in_run: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (count == $past(count)));

    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        busy |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= WIDTH);

endmodule

bind ocnt_top ocnt_chk #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .count (count)
);

// File: tb/sim_ocnt_top.sv
module sim_ocnt_top;

    localparam int WIDTH = 8;
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic             busy, done;
    logic [CNT_W-1:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ocnt_top #(.WIDTH(WIDTH)) u0 (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .din   (din),
        .busy  (busy),
        .done  (done),
        .count (count)
    );

    function automatic int ones_in(input logic [WIDTH-1:0] w);
        int c = 0;
        for (int i = 0; i < WIDTH; i++) c += int'(w[i]);
        return c;
    endfunction

    function automatic int edges_to_done(input logic [WIDTH-1:0] w);
        int low = -1;
        if (w == '0) return 2;
        for (int i = WIDTH - 1; i >= 0; i--) if (w[i]) low = i;
        return 2 + 2 * (WIDTH - low);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // one run; optionally inject a start with another word while busy (R6)
    task automatic run_word(input logic [WIDTH-1:0] w, input bit inject);
        int n = 0;
        bit seen = 1'b0;
        @(negedge clk);
        din   = w;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        check(busy == 1'b1 && count == '0, "R2 load clears tally", int'(count), 0);
        while (!seen && n < 4 * WIDTH + 10) begin
            if (inject && n == 2) begin
                din   = ~w;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                seen = 1'b1;
            end else begin
                @(posedge clk);
                @(negedge clk);
                n++;
            end
        end
        start = 1'b0;
        check(seen, "R4 done observed", int'(seen), 1);
        check(n == edges_to_done(w), inject ? "R6 latency with busy start" : "R5 latency",
              n, edges_to_done(w));
        check(int'(count) == ones_in(w), inject ? "R6 count with busy start" : "R3 count",
              int'(count), ones_in(w));
        @(posedge clk);
        @(negedge clk);
        check(!done && !busy, "R4 done one cycle then idle", int'(done) + 2 * int'(busy), 0);
        repeat (2) @(negedge clk);
        check(int'(count) == ones_in(w), "R7 idle hold", int'(count), ones_in(w));
    endtask

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && count == '0, "R1 reset state", int'(count), 0);

        run_word(8'hFF, 1'b0);   // R8 all ones gives WIDTH
        run_word(8'h00, 1'b0);   // R2 tally cleared, R5 early finish
        run_word(8'h80, 1'b0);   // R5 one shift
        run_word(8'h01, 1'b0);   // R5 full drain
        run_word(8'hA5, 1'b1);   // R6 busy start ignored
        run_word(8'h10, 1'b1);   // R6

        // R1 reset in the middle of a run
        @(negedge clk);
        din   = 8'h3F;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && count == '0, "R1 mid-run reset", int'(busy) + int'(count), 0);

        for (int k = 0; k < 40; k++) begin
            logic [WIDTH-1:0] w;
            w = WIDTH'($urandom);
            run_word(w, (k % 5) == 0);
        end

        finish_up();
    end

endmodule